// File: doc/BRIEF.md
# Eight-Pin Bidirectional GPIO Port

This block is a memory-mapped, eight-pin general-purpose I/O port. It sits on a small register bus. A 2-bit address selects one of four registers: the pin-read view, the output latch, the direction mask and the analog-select mask. For each pin the block produces an output value and an output-enable, and it takes in an input level. The pad buffers, the PWM generator and the parallel-slave engine are outside the block. They connect only through override inputs.

Software sets a pin's direction by writing a 1 (input, driver off) or a 0 (output, latch value driven). A write to the pin-read address or to the latch address stores into the output latch. Reads differ by address: the pin-read address returns the synchronised pin levels, and the latch address returns the stored latch. The four low pins share the comparator inputs and come out of reset in analog mode. In that mode their digital reads return 0. The four high pins can be handed to an external PWM unit one pin at a time. A parallel-mode input hands all eight pins to an external parallel-slave engine.

Top module: `gpio_port`

## Requirements
- R1: After synchronous reset the direction mask reads 8'hFF, the latch reads 8'h00, the analog mask reads 8'h0F, and no pin output-enable is active.
- R2: Outside parallel mode, and with no PWM override on the pin, a direction bit of 1 turns that pin's output-enable off. A direction bit of 0 turns the output-enable on and drives that pin's latch bit.
- R3: A write to address 0 or address 1 stores wdata into the output latch at the next clock edge. A read of address 1 returns the latch contents, independent of the pin levels.
- R4: A read of address 0 returns the pin levels through a two-flop synchroniser. A level present at clock edge k appears on rdata after edge k+1.
- R5: Address 3 holds four analog-select bits in wdata/rdata bits 3:0, which map to pins 0 to 3. Bits 7:4 read as 0 and ignore writes. A pin whose analog bit is 1 reads as 0 at address 0, but its output driver is unaffected.
- R6: Outside parallel mode, pwm_en[j] set forces pin 4+j's output-enable on and drives pwm_val[j] on it, regardless of the direction bit and the latch.
- R7: When par_mode is 1, pin_oe equals par_oe and pin_out equals par_out on all eight pins. This overrides the PWM, the latch and the direction mask.
- R8: Address 2 reads and writes the direction mask, with the new value visible at the next edge. Reads are combinational. When wr_en is 0, no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 pins/latch, 1 latch, 2 direction, 3 analog |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected address |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output-enables, 1 = drive |
| pwm_en | input | 4 | Per-pin PWM override enable for pins 4 to 7 |
| pwm_val | input | 4 | PWM values for pins 4 to 7 |
| par_mode | input | 1 | Hands the whole port to the parallel-slave engine |
| par_out | input | 8 | Output values from the parallel-slave engine |
| par_oe | input | 8 | Output-enables from the parallel-slave engine |

## Verification
The assertions assume that reset is synchronous and is held for at least one edge. They assume that addr, wr_en and the override inputs are known at every edge. They also assume that pin_in may change at any edge, so the synchroniser check is armed only after two edges without reset. The stimulus drives every input on the falling clock edge. It mixes directed sequences with random bus traffic, random pin levels, random PWM and parallel-mode overrides, and occasional reset pulses. A behavioural reference model predicts the bus reads and pin drives on every cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        REG_PORT   = 2'd0,
        REG_LATCH  = 2'd1,
        REG_DIR    = 2'd2,
        REG_ANALOG = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        SRC_LATCH    = 2'd0,
        SRC_PWM      = 2'd1,
        SRC_PARALLEL = 2'd2
    } drv_src_e;

    typedef struct packed {
        logic oe;
        logic val;
    } pin_drv_t;

    // Priority: parallel engine, then PWM, then latch/direction.
    function automatic drv_src_e pick_src(input logic par_mode, input logic pwm_on);
        if (par_mode)    return SRC_PARALLEL;
        else if (pwm_on) return SRC_PWM;
        else             return SRC_LATCH;
    endfunction

    function automatic pin_drv_t make_drv(input drv_src_e src,
                                          input logic dir_bit,
                                          input logic lat_bit,
                                          input logic pwm_bit,
                                          input logic par_oe_bit,
                                          input logic par_val_bit);
        pin_drv_t d;
        unique case (src)
            SRC_PARALLEL: begin d.oe = par_oe_bit; d.val = par_val_bit; end
            SRC_PWM:      begin d.oe = 1'b1;       d.val = pwm_bit;     end
            default:      begin d.oe = ~dir_bit;   d.val = lat_bit;     end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int N_PINS   = 8,
    parameter int N_ANA    = 4,
    parameter int ANA_BASE = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [N_PINS-1:0] wdata,
    input  logic [N_PINS-1:0] pin_view,
    output logic [N_PINS-1:0] rdata,
    output logic [N_PINS-1:0] lat_q,
    output logic [N_PINS-1:0] dir_q,
    output logic [N_PINS-1:0] ana_mask
);
    localparam int PAD_W = N_PINS - N_ANA;

    logic [N_ANA-1:0] ana_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
            dir_q <= '1;
            ana_q <= '1;
        end else if (wr_en) begin
            unique case (sel)
                REG_PORT, REG_LATCH: lat_q <= wdata;
                REG_DIR:             dir_q <= wdata;
                REG_ANALOG:          ana_q <= wdata[N_ANA-1:0];
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < N_PINS; i++) begin : g_ana
        if (i >= ANA_BASE && i < ANA_BASE + N_ANA) begin : g_on
            assign ana_mask[i] = ana_q[i-ANA_BASE];
        end else begin : g_off
            assign ana_mask[i] = 1'b0;
        end
    end

    always_comb begin
        unique case (sel)
            REG_PORT:   rdata = pin_view & ~ana_mask;
            REG_LATCH:  rdata = lat_q;
            REG_DIR:    rdata = dir_q;
            REG_ANALOG: rdata = {{PAD_W{1'b0}}, ana_q};
            default:    rdata = '0;
        endcase
    end

    assert_latch_write_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (sel == REG_PORT || sel == REG_LATCH)) |=> lat_q == $past(wdata));

    assert_dir_write_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == REG_DIR) |=> dir_q == $past(wdata));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(dir_q) && $stable(lat_q) && $stable(ana_q)));

    assert_analog_write_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == REG_ANALOG) |=> ana_q == $past(wdata[N_ANA-1:0]));

endmodule

// File: rtl/gpio_insync.sv
module gpio_insync #(
    parameter int N_PINS = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_sync
);
    logic [N_PINS-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= pin_in;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign pin_sync = stg[STAGES-1];

endmodule

// File: rtl/gpio_outmux.sv
module gpio_outmux
    import gpio_pkg::*;
#(
    parameter int N_PINS   = 8,
    parameter int N_PWM    = 4,
    parameter int PWM_BASE = 4
) (
    input  logic              par_mode,
    input  logic [N_PINS-1:0] dir_q,
    input  logic [N_PINS-1:0] lat_q,
    input  logic [N_PWM-1:0]  pwm_en,
    input  logic [N_PWM-1:0]  pwm_val,
    input  logic [N_PINS-1:0] par_out,
    input  logic [N_PINS-1:0] par_oe,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe
);
    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        logic     pwm_on;
        logic     pwm_bit;
        pin_drv_t drv;

        if (i >= PWM_BASE && i < PWM_BASE + N_PWM) begin : g_pwm
            assign pwm_on  = pwm_en[i-PWM_BASE];
            assign pwm_bit = pwm_val[i-PWM_BASE];
        end else begin : g_plain
            assign pwm_on  = 1'b0;
            assign pwm_bit = 1'b0;
        end

        always_comb begin
            drv = make_drv(pick_src(par_mode, pwm_on),
                           dir_q[i], lat_q[i], pwm_bit, par_oe[i], par_out[i]);
        end

        assign pin_out[i] = drv.val;
        assign pin_oe[i]  = drv.oe;
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int N_PINS      = 8,
    parameter int N_PWM       = 4,
    parameter int PWM_BASE    = 4,
    parameter int N_ANA       = 4,
    parameter int ANA_BASE    = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [N_PINS-1:0] wdata,
    output logic [N_PINS-1:0] rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    input  logic [N_PWM-1:0]  pwm_en,
    input  logic [N_PWM-1:0]  pwm_val,
    input  logic              par_mode,
    input  logic [N_PINS-1:0] par_out,
    input  logic [N_PINS-1:0] par_oe
);
    reg_sel_e          sel;
    logic [N_PINS-1:0] lat_q;
    logic [N_PINS-1:0] dir_q;
    logic [N_PINS-1:0] ana_mask;
    logic [N_PINS-1:0] pin_sync;

    assign sel = reg_sel_e'(addr);

    gpio_insync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin_in(pin_in), .pin_sync(pin_sync)
    );

    gpio_regs #(.N_PINS(N_PINS), .N_ANA(N_ANA), .ANA_BASE(ANA_BASE)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel), .wdata(wdata),
        .pin_view(pin_sync), .rdata(rdata), .lat_q(lat_q), .dir_q(dir_q),
        .ana_mask(ana_mask)
    );

    gpio_outmux #(.N_PINS(N_PINS), .N_PWM(N_PWM), .PWM_BASE(PWM_BASE)) u_mux (
        .par_mode(par_mode), .dir_q(dir_q), .lat_q(lat_q),
        .pwm_en(pwm_en), .pwm_val(pwm_val), .par_out(par_out), .par_oe(par_oe),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // Counts clean edges since reset so the synchroniser check never looks before it.
    logic [1:0] clean_cnt;
    always_ff @(posedge clk) begin
        if (rst)                clean_cnt <= '0;
        else if (clean_cnt != 2'd3) clean_cnt <= clean_cnt + 2'd1;
    end

    assert_parallel_owns_R7: assert property (@(posedge clk) disable iff (rst)
        par_mode |-> (pin_oe == par_oe && pin_out == par_out));

    assert_analog_reads_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (sel == REG_PORT) |-> ((rdata & ana_mask) == '0));

    if (SYNC_STAGES == 2) begin : g_sync_chk
        assert_sync_delay_R4: assert property (@(posedge clk) disable iff (rst)
            (clean_cnt >= 2'd2 && sel == REG_PORT) |-> rdata == ($past(pin_in, 2) & ~ana_mask));
    end

    for (genvar j = 0; j < N_PWM; j++) begin : g_pwm_chk
        assert_pwm_drive_R6: assert property (@(posedge clk) disable iff (rst)
            (!par_mode && pwm_en[j]) |-> (pin_oe[PWM_BASE+j] && pin_out[PWM_BASE+j] == pwm_val[j]));
    end

    for (genvar i = 0; i < N_PINS; i++) begin : g_dir_chk
        if (i < PWM_BASE || i >= PWM_BASE + N_PWM) begin : g_c
            assert_input_tristate_R2: assert property (@(posedge clk) disable iff (rst)
                !par_mode |-> (pin_oe[i] == !dir_q[i]));
        end
    end

endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [1:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic [7:0] pin_in;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic [3:0] pwm_en;
    logic [3:0] pwm_val;
    logic       par_mode;
    logic [7:0] par_out;
    logic [7:0] par_oe;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    gpio_port u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pwm_en(pwm_en), .pwm_val(pwm_val), .par_mode(par_mode),
        .par_out(par_out), .par_oe(par_oe)
    );

    // Behavioural reference state
    logic [7:0] m_lat, m_dir, m_s1, m_s2;
    logic [3:0] m_ana;
    logic [7:0] q_hist[$];

    always @(posedge clk) begin
        if (rst) begin
            m_lat = 8'h00; m_dir = 8'hFF; m_ana = 4'hF; m_s1 = 8'h00; m_s2 = 8'h00;
        end else begin
            if (wr_en) begin
                if (addr == 2'd0 || addr == 2'd1) m_lat = wdata;
                else if (addr == 2'd2)            m_dir = wdata;
                else                              m_ana = wdata[3:0];
            end
            q_hist.push_back(pin_in);
            if (q_hist.size() > 2) void'(q_hist.pop_front());
            m_s2 = m_s1;
            m_s1 = pin_in;
        end
    end

    function automatic logic [7:0] exp_rdata();
        case (addr)
            2'd0:    return m_s2 & ~{4'h0, m_ana};
            2'd1:    return m_lat;
            2'd2:    return m_dir;
            default: return {4'h0, m_ana};
        endcase
    endfunction

    function automatic logic [7:0] exp_oe();
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            if (par_mode)                   r[i] = par_oe[i];
            else if (i >= 4 && pwm_en[i-4]) r[i] = 1'b1;
            else                            r[i] = ~m_dir[i];
        end
        return r;
    endfunction

    function automatic logic [7:0] exp_out();
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            if (par_mode)                   r[i] = par_out[i];
            else if (i >= 4 && pwm_en[i-4]) r[i] = pwm_val[i-4];
            else                            r[i] = m_lat[i];
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h at t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [7:0] eo;
        string rtag, dtag;
        if (rst) return;
        case (addr)
            2'd0:    rtag = "R4 pin read";
            2'd1:    rtag = "R3 latch read";
            2'd2:    rtag = "R8 dir read";
            default: rtag = "R5 analog read";
        endcase
        dtag = par_mode ? "R7 parallel drive" : ((|pwm_en) ? "R6 pwm drive" : "R2 direction drive");
        eo = exp_oe();
        check(rtag, rdata, exp_rdata());
        check({dtag, " oe"}, pin_oe, eo);
        check({dtag, " out"}, pin_out & eo, exp_out() & eo);
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        rst = 1; wr_en = 0; addr = 0; wdata = 0; pin_in = 0;
        pwm_en = 0; pwm_val = 0; par_mode = 0; par_out = 0; par_oe = 0;
        repeat (3) tick();
        rst = 0;
        // R1: reset values
        addr = 2'd2; #1 check("R1 dir after reset", rdata, 8'hFF);
        addr = 2'd3; #1 check("R1 analog after reset", rdata, 8'h0F);
        addr = 2'd1; #1 check("R1 latch after reset", rdata, 8'h00);
        check("R1 oe after reset", pin_oe, 8'h00);

        // R2: direction mask 0xCF -> pins 4,5 driven
        wr_en = 1; addr = 2'd2; wdata = 8'hCF;
        tick();
        #1 check("R2 oe from dir", pin_oe, 8'h30);

        // R3: write via pin address lands in latch
        addr = 2'd0; wdata = 8'hA5;
        tick();
        wr_en = 0; addr = 2'd1; pin_in = 8'hFF;
        #1 check("R3 latch via port addr", rdata, 8'hA5);
        check("R2 driven value", pin_out & pin_oe, 8'h20);
        wr_en = 1; addr = 2'd1; wdata = 8'h5A;
        tick();
        wr_en = 0;
        #1 check("R3 latch not pins", rdata, 8'h5A);

        // R4: synchroniser latency (analog off first)
        wr_en = 1; addr = 2'd3; wdata = 8'h00; pin_in = 8'hF0;
        tick();
        wr_en = 0; addr = 2'd0; pin_in = 8'h3C;
        tick();
        #1 check("R4 one edge old", rdata, 8'hF0);
        tick();
        #1 check("R4 two edges new", rdata, 8'h3C);

        // R5: analog mask, upper bits ignored
        wr_en = 1; addr = 2'd3; wdata = 8'hFF;
        tick();
        wr_en = 0;
        #1 check("R5 upper bits ignored", rdata, 8'h0F);
        addr = 2'd0;
        #1 check("R5 analog pins read 0", rdata, 8'h30);

        // R6: PWM override on pins 4 and 6
        wr_en = 1; addr = 2'd2; wdata = 8'hFF;
        tick();
        wr_en = 0; pwm_en = 4'b0101; pwm_val = 4'b0001;
        #1 check("R6 pwm oe", pin_oe, 8'h50);
        check("R6 pwm value", pin_out & pin_oe, 8'h10);

        // R7: parallel mode wins over PWM
        par_mode = 1; par_oe = 8'h0F; par_out = 8'h09;
        #1 check("R7 parallel oe", pin_oe, 8'h0F);
        check("R7 parallel value", pin_out & pin_oe, 8'h09);
        par_mode = 0; pwm_en = 0;

        // R8: write with wr_en low is ignored
        wr_en = 0; addr = 2'd2; wdata = 8'h00;
        tick();
        #1 check("R8 no write when idle", rdata, 8'hFF);

        // Random traffic compared against the model every cycle
        for (int k = 0; k < 3000; k++) begin
            tick();
            rst      = ($urandom_range(0, 99) == 0);
            wr_en    = $urandom_range(0, 2) == 0;
            addr     = 2'($urandom_range(0, 3));
            wdata    = 8'($urandom);
            pin_in   = 8'($urandom);
            pwm_en   = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
            pwm_val  = 4'($urandom);
            par_mode = ($urandom_range(0, 7) == 0);
            par_out  = 8'($urandom);
            par_oe   = 8'($urandom);
        end
        tick();
        finish_run();
    end

endmodule